// File: doc/BRIEF.md
# Serial EEPROM Page-Write Slave

This block is the target side of a two-wire serial bus (I2C) in front of a 128-byte register-file memory. It watches SCL and SDA through synchronisers and finds START and STOP conditions. It decodes a device select byte and either takes a 7-bit byte address and up to one row of data bytes, or returns a single byte on a read. Accepted data bytes are held in a one-row page buffer. The array is only updated when a write cycle runs, and a write cycle only starts when the master ends the transfer with a STOP in the slot right after an acknowledge.

While the write cycle runs, `busy` is high and the block stays off the bus completely, so a master can poll for completion by sending device select bytes until one is acknowledged. A write-control level, `wr_lock`, protects the array: while it is high, data bytes are refused with a NoAck and are never buffered. SDA is open-drain. The block only ever pulls it low, through `sda_pull`. The board wire-ANDs that pull with the master. There is no data stream at the block's edge, so there is no valid/ready interface: every pin is a plain level.

Top module: `serial_page_eeprom`

## Requirements
- R1: A device select byte whose upper four bits are 1010 is acknowledged on the ninth clock, whatever its three middle bits are. Its bit 0 selects read (1) or write (0). Any other select byte gets no acknowledge, and the bus is ignored until the next START.
- R2: After a write select, the next byte is taken as the byte address (its low 7 bits) and is acknowledged. Every byte after that is a data byte.
- R3: While `wr_lock` is low, each data byte is acknowledged and placed in the page buffer at the position given by the low 4 address bits. After each data byte, those 4 bits step up by one modulo 16 and the upper 3 bits stay as they are.
- R4: If more than 16 data bytes are sent, the position wraps to the start of the same row, and a later byte replaces the earlier byte held at that position.
- R5: While `wr_lock` is high, each data byte gets a NoAck and is not buffered, but the address still steps as in R3.
- R6: A STOP that comes during the first SCL high period after a data-byte acknowledge slot starts a write cycle, provided at least one byte was accepted. `busy` then rises.
- R7: A STOP at any other point, or with no byte accepted, starts no write cycle and leaves the array unchanged.
- R8: `busy` stays high for exactly WRITE_CYCLES clocks. When it ends, every accepted byte is copied into the array at the captured row and its buffered position. All other cells are left unchanged.
- R9: While `busy` is high, the block acknowledges nothing, including a matching device select byte, and never pulls SDA.
- R10: A read select returns the byte at the current address, MSB first, on the eight clocks after the acknowledge. The address then steps by one over the full 7 bits (127 wraps to 0). A random read is a write select plus an address, followed by a repeated START.
- R11: After reset, `busy` is low, SDA is released, the current address is 0 and every array cell reads 0.
- R12: SDA is pulled low only during an acknowledge slot or while read data bits are being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all bus lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire (wired-AND) |
| wr_lock | input | 1 | High refuses data bytes and protects the array |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |
| busy | output | 1 | High while an internal write cycle runs |

## Verification
The hardest situation to reach from the pins is a STOP that lands in the tenth-bit slot, as opposed to one that lands a few bits into the next byte. The two look alike on the wire and differ only in how many SCL highs occur after the acknowledge. The bench's master tasks build both cases on purpose: one ends directly after an acknowledge, and the other clocks a few data bits before the STOP. The bench then reads the array back to show whether a commit happened. Polling during the write cycle is also reached deliberately. The bench sends a select byte straight after the committing STOP, while `busy` is still counting, and the behavioural model predicts which acknowledge bits and read bytes must appear.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} ctrl_st_t;
  typedef enum logic [1:0] {PH_SEL, PH_ADDR, PH_DATA, PH_READ} phase_t;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W*(STAGES+1)-1:0] chain;
  assign chain[W-1:0] = d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[W*(s+1) +: W] <= '1;
      else        chain[W*(s+1) +: W] <= chain[W*s +: W];
    end
  end

  assign q = chain[W*STAGES +: W];
endmodule

// File: rtl/eep_buscond.sv
module eep_buscond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges only count as conditions while the clock line sits high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int         ADDR_W   = 7,
  parameter int         ROW_W    = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010,
  localparam int        HI_W     = ADDR_W - ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_bit,
  input  logic              wr_lock,
  input  logic              busy,
  input  logic              has_data,
  input  logic [7:0]        rd_data,
  output logic              sda_pull,
  output logic              byte_we,
  output logic [ROW_W-1:0]  byte_idx,
  output logic [7:0]        byte_dat,
  output logic              mask_clr,
  output logic              commit,
  output logic [HI_W-1:0]   row,
  output logic [ADDR_W-1:0] rd_addr
);
  ctrl_st_t          st;
  phase_t            ph;
  logic [3:0]        cnt;
  logic [7:0]        shr;
  logic [7:0]        txb;
  logic [ADDR_W-1:0] addr;

  assign row     = addr[ADDR_W-1:ROW_W];
  assign rd_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_SEL;
      cnt      <= '0;
      shr      <= '0;
      txb      <= '0;
      addr     <= '0;
      sda_pull <= 1'b0;
      byte_we  <= 1'b0;
      byte_idx <= '0;
      byte_dat <= '0;
      mask_clr <= 1'b0;
      commit   <= 1'b0;
    end else begin
      byte_we  <= 1'b0;
      mask_clr <= 1'b0;
      commit   <= 1'b0;
      if (busy) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        st       <= ST_RX;
        ph       <= PH_SEL;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
        // one SCL high since the acknowledge means the tenth-bit slot
        if (st == ST_RX && ph == PH_DATA && cnt == 4'd1 && has_data)
          commit <= 1'b1;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              shr <= {shr[6:0], sda_bit};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (ph)
                PH_SEL: begin
                  if (shr[7:4] == DEV_CODE) begin
                    st       <= ST_ACK;
                    sda_pull <= 1'b1;
                    ph       <= shr[0] ? PH_READ : PH_ADDR;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_ADDR: begin
                  addr     <= shr[ADDR_W-1:0];
                  mask_clr <= 1'b1;
                  st       <= ST_ACK;
                  sda_pull <= 1'b1;
                  ph       <= PH_DATA;
                end
                PH_DATA: begin
                  st       <= ST_ACK;
                  sda_pull <= !wr_lock;
                  byte_we  <= !wr_lock;
                  byte_idx <= addr[ROW_W-1:0];
                  byte_dat <= shr;
                  addr     <= {addr[ADDR_W-1:ROW_W], addr[ROW_W-1:0] + 1'b1};
                end
                default: st <= ST_IDLE;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (ph == PH_READ) begin
                st       <= ST_TX;
                txb      <= rd_data;
                sda_pull <= !rd_data[7];
              end else begin
                st       <= ST_RX;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                st       <= ST_MACK;
                sda_pull <= 1'b0;
                addr     <= addr + 1'b1;
              end else begin
                txb      <= {txb[6:0], 1'b0};
                sda_pull <= !txb[6];
              end
            end
          end
          ST_MACK: if (scl_fall) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  a_r9_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);
  a_r12_drive_slots: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (st == ST_ACK || st == ST_TX));
  a_r3_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |-> addr[ADDR_W-1:ROW_W] == $past(addr[ADDR_W-1:ROW_W]));
  a_r5_lock_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |-> !$past(wr_lock));
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int  ADDR_W       = 7,
  parameter int  ROW_W        = 4,
  parameter int  WRITE_CYCLES = 600,
  localparam int HI_W         = ADDR_W - ROW_W,
  localparam int ROW_B        = 1 << ROW_W,
  localparam int DEPTH        = 1 << ADDR_W,
  localparam int TW           = $clog2(WRITE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [ROW_W-1:0]  byte_idx,
  input  logic [7:0]        byte_dat,
  input  logic              mask_clr,
  input  logic              commit,
  input  logic [HI_W-1:0]   row,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              has_data
);
  logic [7:0]       page [ROW_B];
  logic [ROW_B-1:0] mask;
  logic [HI_W-1:0]  row_q;
  logic [TW-1:0]    tmr;
  logic             done;
  logic [7:0]       cells [DEPTH];

  assign done     = busy && (tmr == TW'(WRITE_CYCLES - 1));
  assign has_data = |mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      for (int i = 0; i < ROW_B; i++) page[i] <= '0;
    end else if (mask_clr || done) begin
      mask <= '0;
    end else if (byte_we) begin
      page[byte_idx] <= byte_dat;
      mask[byte_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tmr   <= '0;
      row_q <= '0;
    end else if (commit) begin
      busy  <= 1'b1;
      tmr   <= '0;
      row_q <= row;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      tmr  <= tmr + 1'b1;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    localparam int COL = e % ROW_B;
    localparam int RW  = e / ROW_B;
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= '0;
      else if (done && row_q == HI_W'(RW) && mask[COL]) cell_q <= page[COL];
    end
    assign cells[e] = cell_q;
  end

  assign rd_data = cells[rd_addr];

  // independent length counter for the busy window
  logic [TW:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_cnt <= '0;
    else if (busy) hi_cnt <= hi_cnt + 1'b1;
    else           hi_cnt <= '0;
  end

  a_r6_commit_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> has_data);
  a_r9_no_store_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!byte_we && !mask_clr));
  a_r7_no_commit_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit);
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> hi_cnt == (TW+1)'(WRITE_CYCLES));
endmodule

// File: rtl/serial_page_eeprom.sv
module serial_page_eeprom #(
  parameter int         ADDR_W       = 7,
  parameter int         ROW_W        = 4,
  parameter int         WRITE_CYCLES = 600,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [3:0] DEV_CODE     = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wr_lock,
  output logic sda_pull,
  output logic busy
);
  localparam int HI_W = ADDR_W - ROW_W;

  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              byte_we, mask_clr, commit, has_data;
  logic [ROW_W-1:0]  byte_idx;
  logic [7:0]        byte_dat, rd_data;
  logic [HI_W-1:0]   row;
  logic [ADDR_W-1:0] rd_addr;

  eep_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
  );

  eep_buscond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_ctrl #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_s),
    .wr_lock(wr_lock), .busy(busy), .has_data(has_data), .rd_data(rd_data),
    .sda_pull(sda_pull), .byte_we(byte_we), .byte_idx(byte_idx),
    .byte_dat(byte_dat), .mask_clr(mask_clr), .commit(commit),
    .row(row), .rd_addr(rd_addr)
  );

  eep_store #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .byte_we(byte_we), .byte_idx(byte_idx), .byte_dat(byte_dat),
    .mask_clr(mask_clr), .commit(commit), .row(row), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .has_data(has_data)
  );
endmodule

// File: tb/tb_serial_page_eeprom.sv
module tb_serial_page_eeprom;
  localparam int WC = 600;
  localparam int Q  = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wr_lock = 1'b0;
  logic sda_pull, busy, sda_bus;
  assign sda_bus = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  serial_page_eeprom #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .wr_lock(wr_lock), .sda_pull(sda_pull), .busy(busy)
  );

  int total = 0, bad = 0, mon_bad = 0, run = 0, last_len = 0;
  bit nodrive = 0, finished = 0;
  logic [7:0] mem_m [128];
  int addr_m = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock comparison: the model forbids any pull while the master owns SDA or busy is high
  always @(negedge clk) begin
    if (rst_n) begin
      if ((nodrive || busy) && sda_pull) mon_bad++;
      if (busy) run++;
      else if (run != 0) begin last_len = run; run = 0; end
    end
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start();
    sda_m = 1; wt(Q); scl_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(Q);
  endtask
  task automatic bus_stop();
    sda_m = 0; wt(Q); scl_m = 1; wt(Q); sda_m = 1; wt(Q);
  endtask
  task automatic put_bit(input bit b);
    sda_m = b; wt(Q); scl_m = 1; nodrive = 1; wt(2*Q); nodrive = 0; scl_m = 0; wt(Q);
  endtask
  task automatic get_bit(output bit b);
    sda_m = 1; wt(Q); scl_m = 1; wt(Q); b = sda_bus; wt(Q); scl_m = 0; wt(Q);
  endtask
  task automatic put_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask
  task automatic get_byte(output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(1'b1);
  endtask

  task automatic write_txn(input int a, input int n, input int seed, input bit locked);
    bit ack, any;
    logic [7:0] v;
    logic [7:0] pend [16];
    bit pv [16];
    int idx;
    for (int k = 0; k < 16; k++) pv[k] = 0;
    bus_start();
    put_byte(8'hAE, ack); chk(ack, "R1 select ack (middle bits set)", ack, 1);
    put_byte(8'(a), ack); chk(ack, "R2 address ack", ack, 1);
    idx = a & 15; any = 0;
    for (int k = 0; k < n; k++) begin
      v = 8'((seed + k * 37) & 255);
      put_byte(v, ack);
      if (locked) chk(!ack, "R5 locked byte gets NoAck", ack, 0);
      else        chk(ack, "R3 data byte ack", ack, 1);
      if (!locked) begin pend[idx] = v; pv[idx] = 1; any = 1; end
      idx = (idx + 1) & 15;
    end
    bus_stop(); wt(8);
    if (any) chk(busy == 1'b1, "R6 stop in tenth slot starts write", busy, 1);
    else     chk(busy == 1'b0, "R7 no accepted byte, no write", busy, 0);
    if (any) begin
      while (busy) wt(1);
      wt(2);
      chk(last_len == WC, "R8 busy length", last_len, WC);
      for (int k = 0; k < 16; k++) if (pv[k]) mem_m[(a & 'h70) | k] = pend[k];
    end
    addr_m = (a & 'h70) | idx;
  endtask

  task automatic read_rand(input int a, input string req);
    bit ack;
    logic [7:0] v;
    bus_start();
    put_byte(8'hA2, ack); chk(ack, "R1 select ack", ack, 1);
    put_byte(8'(a), ack); chk(ack, "R2 address ack", ack, 1);
    bus_start();
    put_byte(8'hA3, ack); chk(ack, "R10 read select ack", ack, 1);
    get_byte(v);
    bus_stop(); wt(4);
    chk(v == mem_m[a], req, v, mem_m[a]);
    addr_m = (a + 1) & 127;
  endtask

  task automatic read_cur(input string req);
    bit ack;
    logic [7:0] v;
    int exp;
    bus_start();
    put_byte(8'hA1, ack); chk(ack, "R10 current read select ack", ack, 1);
    get_byte(v);
    bus_stop(); wt(4);
    exp = mem_m[addr_m];
    chk(v == 8'(exp), req, v, exp);
    addr_m = (addr_m + 1) & 127;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    for (int i = 0; i < 128; i++) mem_m[i] = 8'h00;
    wt(5); rst_n = 1; wt(5);
    chk(busy == 1'b0, "R11 busy low after reset", busy, 0);
    chk(sda_pull == 1'b0, "R11 SDA released after reset", sda_pull, 0);
    read_cur("R11 address 0 reads zero");

    // single byte write, then a poll while busy
    bus_start();
    put_byte(8'hA0, ack); chk(ack, "R1 select ack", ack, 1);
    put_byte(8'h25, ack); chk(ack, "R2 address ack", ack, 1);
    put_byte(8'hC3, ack); chk(ack, "R3 data ack", ack, 1);
    bus_stop(); wt(8);
    chk(busy == 1'b1, "R6 single byte write starts cycle", busy, 1);
    bus_start();
    put_byte(8'hA0, ack); chk(!ack, "R9 no ack while busy", ack, 0);
    bus_stop();
    while (busy) wt(1);
    wt(2);
    chk(last_len == WC, "R8 busy length", last_len, WC);
    mem_m[8'h25] = 8'hC3;
    bus_start();
    put_byte(8'hA0, ack); chk(ack, "R9 ack once idle", ack, 1);
    bus_stop(); wt(8);
    chk(busy == 1'b0, "R7 stop after select only", busy, 0);
    read_rand('h25, "R8 single byte stored");
    read_rand('h24, "R8 neighbour untouched");

    // full page at a row start
    write_txn('h30, 16, 11, 0);
    read_rand('h30, "R3 page byte 0");
    for (int k = 1; k < 16; k++) read_cur("R3 page byte");

    // write crossing the row end wraps inside the row
    write_txn('h4E, 5, 90, 0);
    read_rand('h4E, "R4 before wrap");
    read_cur("R4 last of row");
    read_rand('h40, "R4 wrapped to row start");
    read_cur("R4 wrapped second");
    read_cur("R4 wrapped third");
    read_rand('h50, "R4 next row untouched");

    // more than 16 bytes overwrite the earliest
    write_txn('h10, 18, 200, 0);
    read_rand('h10, "R4 overwritten position 0");
    read_cur("R4 overwritten position 1");
    read_cur("R4 position 2 kept");

    // write-protected transfer
    wr_lock = 1;
    write_txn('h25, 2, 7, 1);
    wr_lock = 0;
    read_cur("R5 address advanced while locked");
    read_rand('h25, "R5 locked bytes not stored");

    // STOP a few bits into a data byte
    bus_start();
    put_byte(8'hA0, ack); chk(ack, "R1 select ack", ack, 1);
    put_byte(8'h60, ack); chk(ack, "R2 address ack", ack, 1);
    put_byte(8'h55, ack); chk(ack, "R3 data ack", ack, 1);
    put_bit(1); put_bit(0); put_bit(1);
    bus_stop(); wt(8);
    chk(busy == 1'b0, "R7 late stop aborts", busy, 0);
    wt(WC + 20);
    read_rand('h60, "R7 aborted byte not stored");

    // address-only transfer sets the pointer
    bus_start();
    put_byte(8'hA0, ack);
    put_byte(8'h33, ack); chk(ack, "R2 address ack", ack, 1);
    bus_stop(); wt(8);
    chk(busy == 1'b0, "R7 no data, no write", busy, 0);
    addr_m = 'h33;
    read_cur("R2 pointer loaded by address byte");

    // foreign device code is ignored
    bus_start();
    put_byte(8'h90, ack); chk(!ack, "R1 foreign select no ack", ack, 0);
    put_byte(8'h12, ack); chk(!ack, "R1 bus ignored after foreign select", ack, 0);
    bus_stop(); wt(8);
    chk(busy == 1'b0, "R1 no write from foreign select", busy, 0);

    // full 7-bit wrap of the read pointer
    write_txn('h7F, 1, 154, 0);
    write_txn('h00, 1, 61, 0);
    read_rand('h7F, "R10 last cell");
    read_cur("R10 pointer wraps to 0");

    chk(mon_bad == 0, "R12 SDA left to master / R9 quiet when busy", mon_bad, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule